// File: doc/BRIEF.md
# Bit-Field Deposit Unit

This block performs the field-insert step of a 32-bit integer pipeline. It takes an instruction word and writes a contiguous field of chosen length and position into a result word. The bits outside the field are either cleared or kept from the current contents of the destination register. The field contents come from a source register or from a small signed immediate. The position comes either from immediate bits of the instruction or from the shift-amount register. The shift-amount register counts bit positions from the most significant end.

The surrounding pipeline reads the destination and source registers and the shift-amount register, then presents them with the instruction and a valid strobe. One cycle later the unit returns the result, the destination index, a write enable and the 3-bit condition field. The condition field is passed on for the nullification logic, which sits outside this block. The register file also sits outside this block.

Top module: `bfdep_unit`

## Requirements
- R1: An instruction is claimed only when bits 31:26 equal 0x35 and the low bits match one of three forms. The variable-position form has bit 11 = 0 and bits 9:5 = 0. The register-at-immediate form has bits 12:11 = 01. The immediate-at-immediate form has bits 12:11 = 11. An unclaimed instruction produces no `out_valid` and no `wr_en`.
- R2: `out_valid` rises in the cycle after a claimed `in_valid` and lasts one cycle. After reset, `out_valid`, `wr_en` and `result` are 0.
- R3: The field length is 32 minus bits 4:0, so a value of 0 gives a full 32-bit field.
- R4: In the two immediate-position forms, the field's lowest bit sits at the position given by bits 9:5, counted from bit 0. A field that would run past bit 31 is cut at bit 31.
- R5: With bit 10 = 0, every result bit outside the field is 0. With bit 10 = 1, those bits keep the value of `tgt_val`.
- R6: The immediate-at-immediate form inserts the 5-bit signed immediate in bits 20:16, sign-extended. The register-at-immediate form inserts `src_val`, the register named by bits 20:16.
- R7: In the variable-position form, the field's lowest bit sits at `sar` XOR 31. Bit 12 = 1 selects the sign-extended immediate and bit 12 = 0 selects `src_val`. Field bits pushed past bit 31 are dropped.
- R8: A register index of 0 reads as zero, for the source (bits 20:16) and for the destination used in merge mode (bits 25:21).
- R9: `wr_idx` carries bits 25:21 and `cond` carries bits 15:13. `wr_en` is high only with `out_valid` and a nonzero `wr_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction and operands present |
| insn | input | 32 | Instruction word |
| tgt_val | input | 32 | Current value of the destination register |
| src_val | input | 32 | Value of the source register |
| sar | input | 5 | Shift-amount register, numbered from the most significant bit |
| out_valid | output | 1 | One-cycle strobe for a claimed instruction |
| result | output | 32 | Deposited word |
| wr_idx | output | 5 | Destination register index |
| wr_en | output | 1 | Write request to the register file |
| cond | output | 3 | Condition field for later nullification |

## Verification
The bench goes after fields that overrun bit 31, in both the clipped immediate form and the variable form. A design that wrapped the field or skipped the clip would corrupt the low bits. It checks the full-length field (length code 0), where a 5-bit length would collapse to an empty field. It checks the position reversal in the variable form, where a design that forgot the XOR would place the field at the mirrored bit. It also checks negative immediates, which a design without sign extension would insert zero-padded. Further cases cover near-miss encodings that a loose decoder would claim, and index 0 as source or destination, which a careless design would read as live data or write.

// File: rtl/bfdep_pkg.sv
package bfdep_pkg;
   localparam logic [5:0] MAJOR_DEPOSIT = 6'h35;

   typedef enum logic [1:0] {
      FORM_NONE,
      FORM_VARPOS,
      FORM_REGIMM,
      FORM_IMMIMM
   } dep_form_e;

   typedef struct packed {
      logic      hit;
      dep_form_e form;
      logic      merge;
      logic      use_imm;
      logic [4:0] clen;
      logic [4:0] ipos;
      logic [4:0] tgt_idx;
      logic [4:0] src_idx;
      logic [2:0] cond;
      logic [4:0] imm5;
   } dep_fields_t;
endpackage

// File: rtl/bfdep_decode.sv
module bfdep_decode
   import bfdep_pkg::*;
(
   input  logic [31:0] insn,
   output dep_fields_t fields
);
   logic major_ok;

   always_comb begin
      major_ok       = (insn[31:26] == MAJOR_DEPOSIT);
      fields         = '0;
      fields.clen    = insn[4:0];
      fields.ipos    = insn[9:5];
      fields.merge   = insn[10];
      fields.cond    = insn[15:13];
      fields.src_idx = insn[20:16];
      fields.imm5    = insn[20:16];
      fields.tgt_idx = insn[25:21];
      fields.form    = FORM_NONE;
      if (major_ok) begin
         if (!insn[11] && (insn[9:5] == 5'd0))
            fields.form = FORM_VARPOS;
         else if (insn[12:11] == 2'b01)
            fields.form = FORM_REGIMM;
         else if (insn[12:11] == 2'b11)
            fields.form = FORM_IMMIMM;
      end
      fields.hit     = (fields.form != FORM_NONE);
      fields.use_imm = (fields.form == FORM_IMMIMM) ||
                       ((fields.form == FORM_VARPOS) && insn[12]);
   end
endmodule

// File: rtl/bfdep_field_mask.sv
module bfdep_field_mask #(
   parameter  int XLEN       = 32,
   parameter  int MASK_STYLE = 0,
   localparam int POSW       = $clog2(XLEN),
   localparam int LENW       = POSW + 1
) (
   input  logic [POSW-1:0] pos,
   input  logic [LENW-1:0] len,
   output logic [XLEN-1:0] mask
);
   generate
      if (MASK_STYLE == 0) begin : g_shift
         logic [XLEN-1:0] low_ones;
         always_comb begin
            if (len == LENW'(XLEN))
               low_ones = '1;
            else
               low_ones = (XLEN'(1) << len) - XLEN'(1);
            mask = low_ones << pos;
         end
      end else begin : g_compare
         logic [LENW:0] lim;
         assign lim = (LENW+1)'(pos) + (LENW+1)'(len);
         for (genvar i = 0; i < XLEN; i++) begin : g_bit
            assign mask[i] = ((LENW+1)'(i) >= (LENW+1)'(pos)) &&
                             ((LENW+1)'(i) < lim);
         end
      end
   endgenerate
endmodule

// File: rtl/bfdep_merge.sv
module bfdep_merge #(
   parameter  int XLEN = 32,
   localparam int POSW = $clog2(XLEN)
) (
   input  logic [XLEN-1:0] value,
   input  logic [XLEN-1:0] base,
   input  logic [XLEN-1:0] mask,
   input  logic [POSW-1:0] pos,
   input  logic            merge,
   output logic [XLEN-1:0] word
);
   logic [XLEN-1:0] placed;
   logic [XLEN-1:0] kept;

   always_comb begin
      placed = (value << pos) & mask;
      kept   = merge ? (base & ~mask) : '0;
      word   = placed | kept;
   end
endmodule

// File: rtl/bfdep_unit.sv
module bfdep_unit
   import bfdep_pkg::*;
#(
   parameter  int XLEN       = 32,
   parameter  int MASK_STYLE = 0,
   localparam int POSW       = $clog2(XLEN),
   localparam int LENW       = POSW + 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            in_valid,
   input  logic [31:0]     insn,
   input  logic [XLEN-1:0] tgt_val,
   input  logic [XLEN-1:0] src_val,
   input  logic [POSW-1:0] sar,
   output logic            out_valid,
   output logic [XLEN-1:0] result,
   output logic [4:0]      wr_idx,
   output logic            wr_en,
   output logic [2:0]      cond
);
   generate
      if (XLEN != 32) begin : g_bad_width
         $error("bfdep_unit: instruction fields fix XLEN at 32");
      end
      if ((MASK_STYLE != 0) && (MASK_STYLE != 1)) begin : g_bad_style
         $error("bfdep_unit: MASK_STYLE must be 0 or 1");
      end
   endgenerate

   dep_fields_t     f;
   logic [LENW-1:0] fld_len;
   logic [POSW-1:0] fld_pos;
   logic [XLEN-1:0] imm_ext;
   logic [XLEN-1:0] src_eff;
   logic [XLEN-1:0] base_eff;
   logic [XLEN-1:0] ins_val;
   logic [XLEN-1:0] fld_mask;
   logic [XLEN-1:0] word;

   bfdep_decode u_dec (
      .insn   (insn),
      .fields (f)
   );

   always_comb begin
      fld_len  = LENW'(XLEN) - LENW'(f.clen);
      fld_pos  = (f.form == FORM_VARPOS) ? (sar ^ POSW'(XLEN-1)) : f.ipos;
      imm_ext  = {{(XLEN-5){f.imm5[4]}}, f.imm5};
      src_eff  = (f.src_idx == 5'd0) ? '0 : src_val;
      base_eff = (f.tgt_idx == 5'd0) ? '0 : tgt_val;
      ins_val  = f.use_imm ? imm_ext : src_eff;
   end

   bfdep_field_mask #(.XLEN(XLEN), .MASK_STYLE(MASK_STYLE)) u_mask (
      .pos  (fld_pos),
      .len  (fld_len),
      .mask (fld_mask)
   );

   bfdep_merge #(.XLEN(XLEN)) u_merge (
      .value (ins_val),
      .base  (base_eff),
      .mask  (fld_mask),
      .pos   (fld_pos),
      .merge (f.merge),
      .word  (word)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         wr_idx    <= '0;
         wr_en     <= 1'b0;
         cond      <= '0;
      end else begin
         out_valid <= in_valid && f.hit;
         wr_en     <= in_valid && f.hit && (f.tgt_idx != 5'd0);
         if (in_valid && f.hit) begin
            result <= word;
            wr_idx <= f.tgt_idx;
            cond   <= f.cond;
         end
      end
   end
endmodule

// File: rtl/bfdep_checker.sv
module bfdep_checker #(
   parameter  int XLEN = 32,
   localparam int POSW = $clog2(XLEN)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic [31:0]     insn,
   input logic            out_valid,
   input logic [XLEN-1:0] result,
   input logic [4:0]      wr_idx,
   input logic            wr_en
);
   assert_valid_needs_input_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);

   assert_write_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (out_valid && (wr_idx != 5'd0)));

   assert_foreign_major_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (insn[31:26] != 6'h35)) |=> !out_valid);

   assert_full_imm_field_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && (insn[31:26] == 6'h35) && (insn[12:11] == 2'b11) &&
       (insn[10:0] == 11'd0))
      |=> (out_valid &&
           (result == {{(XLEN-5){$past(insn[20])}}, $past(insn[20:16])})));
endmodule

bind bfdep_unit bfdep_checker #(.XLEN(XLEN)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .insn      (insn),
   .out_valid (out_valid),
   .result    (result),
   .wr_idx    (wr_idx),
   .wr_en     (wr_en)
);

// File: tb/sim_bfdep_unit.sv
module sim_bfdep_unit;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [31:0] insn = '0;
   logic [31:0] tgt_val = '0;
   logic [31:0] src_val = '0;
   logic [4:0]  sar = '0;
   logic        out_valid;
   logic [31:0] result;
   logic [4:0]  wr_idx;
   logic        wr_en;
   logic [2:0]  cond;

   int n_run = 0;
   int n_fail = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   bfdep_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .insn(insn),
      .tgt_val(tgt_val), .src_val(src_val), .sar(sar),
      .out_valid(out_valid), .result(result), .wr_idx(wr_idx),
      .wr_en(wr_en), .cond(cond)
   );

   function automatic logic [31:0] enc_imm(input logic [4:0] t, input logic [4:0] imm,
      input logic [2:0] c, input logic nz, input logic [4:0] p, input logic [4:0] clen);
      return {6'h35, t, imm, c, 2'b11, nz, p, clen};
   endfunction

   function automatic logic [31:0] enc_reg(input logic [4:0] t, input logic [4:0] r,
      input logic [2:0] c, input logic nz, input logic [4:0] p, input logic [4:0] clen);
      return {6'h35, t, r, c, 2'b01, nz, p, clen};
   endfunction

   function automatic logic [31:0] enc_var(input logic [4:0] t, input logic [4:0] r,
      input logic [2:0] c, input logic use_i, input logic nz, input logic [4:0] clen);
      return {6'h35, t, r, c, use_i, 1'b0, nz, 5'd0, clen};
   endfunction

   // Bit-by-bit model of R3..R8
   function automatic logic [31:0] model(input logic [31:0] ins, input logic [31:0] tgt,
      input logic [31:0] src, input logic [4:0] s);
      int len = 32 - int'(ins[4:0]);
      int pos = ins[11] ? int'(ins[9:5]) : 31 - int'(s);
      logic [31:0] v;
      logic [31:0] b;
      logic [31:0] r;
      if (ins[12]) v = {{27{ins[20]}}, ins[20:16]};
      else         v = (ins[20:16] == 5'd0) ? 32'd0 : src;
      b = (ins[10] && ins[25:21] != 5'd0) ? tgt : 32'd0;
      for (int k = 0; k < 32; k++) begin
         if (k >= pos && k < pos + len) r[k] = v[k-pos];
         else                           r[k] = b[k];
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [31:0] ins, input logic [31:0] tgt,
      input logic [31:0] src, input logic [4:0] s);
      @(negedge clk);
      insn = ins; tgt_val = tgt; src_val = src; sar = s; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic run_claimed(input string req, input logic [31:0] ins,
      input logic [31:0] tgt, input logic [31:0] src, input logic [4:0] s);
      issue(ins, tgt, src, s);
      check({req, " out_valid"}, 32'(out_valid), 32'd1);
      check({req, " result"}, result, model(ins, tgt, src, s));
      check({req, " wr_idx R9"}, 32'(wr_idx), 32'(ins[25:21]));
      check({req, " wr_en R9"}, 32'(wr_en), 32'(ins[25:21] != 5'd0));
      check({req, " cond R9"}, 32'(cond), 32'(ins[15:13]));
   endtask

   task automatic run_rejected(input string req, input logic [31:0] ins);
      issue(ins, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 5'd3);
      check({req, " out_valid"}, 32'(out_valid), 32'd0);
      check({req, " wr_en"}, 32'(wr_en), 32'd0);
   endtask

   task automatic t_reset();
      check("R2 reset out_valid", 32'(out_valid), 32'd0);
      check("R2 reset wr_en", 32'(wr_en), 32'd0);
      check("R2 reset result", result, 32'd0);
   endtask

   task automatic t_pulse();
      issue(enc_imm(5'd4, 5'd7, 3'd0, 1'b0, 5'd0, 5'd28), 0, 0, 0);
      @(negedge clk);
      check("R2 strobe one cycle", 32'(out_valid), 32'd0);
   endtask

   task automatic t_imm_zero();
      run_claimed("R6 R5 imm zero", enc_imm(5'd3, 5'h1D, 3'd2, 1'b0, 5'd4, 5'd28),
                  32'hFFFF_FFFF, 32'h0, 5'd0);
      check("R6 literal neg imm", result, 32'h0000_00D0);
   endtask

   task automatic t_imm_merge();
      run_claimed("R5 imm merge", enc_imm(5'd9, 5'h05, 3'd5, 1'b1, 5'd12, 5'd26),
                  32'hA5A5_A5A5, 32'h0, 5'd0);
      check("R5 literal merge", result, 32'hA5A4_55A5);
   endtask

   task automatic t_reg();
      run_claimed("R6 reg form", enc_reg(5'd7, 5'd2, 3'd1, 1'b0, 5'd8, 5'd20),
                  32'h0, 32'h1234_5678, 5'd0);
      run_claimed("R5 reg merge", enc_reg(5'd7, 5'd2, 3'd6, 1'b1, 5'd3, 5'd27),
                  32'hDEAD_BEEF, 32'h0000_0015, 5'd0);
   endtask

   task automatic t_clip();
      run_claimed("R4 clip", enc_imm(5'd1, 5'h1F, 3'd0, 1'b0, 5'd28, 5'd24), 0, 0, 0);
      check("R4 literal clip", result, 32'hF000_0000);
      run_claimed("R4 clip merge", enc_reg(5'd1, 5'd5, 3'd0, 1'b1, 5'd30, 5'd16),
                  32'h0F0F_0F0F, 32'hFFFF_FFFF, 5'd0);
   endtask

   task automatic t_full();
      run_claimed("R3 full length", enc_reg(5'd6, 5'd8, 3'd3, 1'b1, 5'd0, 5'd0),
                  32'h1111_1111, 32'hCAFE_F00D, 5'd0);
      check("R3 literal full", result, 32'hCAFE_F00D);
   endtask

   task automatic t_var();
      run_claimed("R7 var reg sar0", enc_var(5'd2, 5'd3, 3'd0, 1'b0, 1'b0, 5'd24),
                  32'h0, 32'h0000_0001, 5'd0);
      check("R7 literal drop", result, 32'h8000_0000);
      run_claimed("R7 var imm merge", enc_var(5'd2, 5'h1A, 3'd4, 1'b1, 1'b1, 5'd26),
                  32'h5555_5555, 32'h0, 5'd27);
      run_claimed("R7 var reg mid", enc_var(5'd11, 5'd4, 3'd7, 1'b0, 1'b1, 5'd16),
                  32'h0123_4567, 32'h89AB_CDEF, 5'd15);
   endtask

   task automatic t_reject();
      run_rejected("R1 other major", {6'h34, 26'h0000_1800});
      run_rejected("R1 var bad pos bits", {6'h35, 5'd3, 5'd4, 3'd0, 1'b0, 1'b0, 1'b0, 5'd6, 5'd0});
   endtask

   task automatic t_zero_idx();
      run_claimed("R8 R9 tgt idx0", enc_imm(5'd0, 5'h03, 3'd1, 1'b1, 5'd0, 5'd30),
                  32'hFFFF_FFFF, 32'h0, 5'd0);
      check("R8 literal tgt0", result, 32'h0000_0003);
      run_claimed("R8 src idx0", enc_reg(5'd5, 5'd0, 3'd0, 1'b0, 5'd0, 5'd0),
                  32'h0, 32'hFFFF_FFFF, 5'd0);
      check("R8 literal src0", result, 32'h0);
   endtask

   initial begin
      #(20 * 150000);
      if (!finished) begin
         n_fail++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_pulse();
      t_imm_zero();
      t_imm_merge();
      t_reg();
      t_clip();
      t_full();
      t_var();
      t_reject();
      t_zero_idx();
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule